// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream, carried on a bit clock, a frame clock and one data line, into parallel 16-bit left and right samples. Everything runs in the bit-clock domain: the frame clock and the data line are sampled on each rising bit-clock edge. The block presents each finished stereo pair together, with a one-cycle valid strobe.

The block accepts three framings. A single format pin chooses between I2S and right-justified framing. A frame clock whose high pulse lasts only a few bit clocks is taken as a sync pulse, and the block then switches to DSP (time-division) framing on its own. While DSP framing is in use, the same pin chooses which edge carries the first data bit. The block measures every frame-clock level. A level too short to hold a 16-bit word raises a framing-error pulse, and the frame it belongs to produces no output.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, left_o, right_o, valid_o and frame_err_o are all 0.
- R2: With fmt_sel_i=0 and no sync pulses, the block uses I2S framing. A frame-clock change counts from the first rising edge on which the new level is sampled. The sample MSB is taken on the next rising edge, and 16 bits follow MSB first. Frame clock low carries the left sample and high carries the right sample. Any further bits in the level are ignored.
- R3: With fmt_sel_i=1 and no sync pulses, the block uses right-justified framing. A word is the 16 bits sampled on the 16 rising edges just before the edge that first sees a frame-clock change, with its LSB last. Frame clock high carries the left sample and low carries the right sample. Earlier bits are ignored, and each level may have any length of 16 edges or more.
- R4: A frame-clock high level of 1 to 4 rising edges marks a sync pulse. It selects DSP framing and never raises frame_err_o.
- R5: In DSP framing with fmt_sel_i=0, the left MSB is taken on the second rising edge that sees the frame clock high. The 16 left bits and then the 16 right bits follow MSB first. Later bits up to the next sync are ignored.
- R6: In DSP framing with fmt_sel_i=1, the left MSB is taken on the first rising edge that sees the frame clock high. The rest follows the same order as R5.
- R7: Once the right word of a frame is complete, left_o and right_o update together and valid_o is high for exactly one cycle. This happens once per complete frame, one cycle after the edge that takes the last bit (for right-justified framing, the edge that sees the frame-clock change).
- R8: Outside DSP framing, a frame-clock level shorter than 16 rising edges raises frame_err_o for one cycle. This does not apply to the first level after reset or to a sync pulse of R4. The frame that contains such a level gives no valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all sampling on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Frame clock |
| sdata_i | input | 1 | Serial audio data |
| fmt_sel_i | input | 1 | 0: I2S, or DSP with late MSB; 1: right-justified, or DSP with early MSB |
| left_o | output | 16 | Left sample of the last complete frame |
| right_o | output | 16 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is presented |
| frame_err_o | output | 1 | One-cycle pulse on a frame-clock level that is too short |

## Verification
The hardest condition to reach from the ports is the boundary between a sync pulse and a level that is merely too short. A four-edge high pulse must switch to DSP framing silently, while a five-edge pulse in I2S traffic must flag an error and cancel a left sample that was already captured. The stimulus builds whole bit streams in the bench. It fills every data slot with pseudo-random filler, places the sample words at positions computed from each framing rule, and sweeps the level lengths from the 16-edge minimum upward and the sync width from 1 to 4. Error streams place the short level between good frames, so that both the missing output and the recovery on the next frame are observed.

// File: rtl/serial_audio_pkg.sv
package serial_audio_pkg;
  typedef struct packed {
    logic any;     // level change seen at this edge
    logic rise;
    logic fall;
    logic synced;  // at least one change seen since reset
  } lr_evt_t;

  typedef enum logic [1:0] {CAP_I2S, CAP_RJ, CAP_DSP} cap_mode_e;
endpackage

// File: rtl/lrck_timer.sv
module lrck_timer
  import serial_audio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  output lr_evt_t          evt_o,
  output logic [CNT_W-1:0] len_o,
  output logic             lvl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lrck_q;
  logic             synced_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    evt_o.any    = lrck_i ^ lrck_q;
    evt_o.rise   = evt_o.any & lrck_i;
    evt_o.fall   = evt_o.any & ~lrck_i;
    evt_o.synced = synced_q;
  end

  // at a change edge len_o equals the length of the level just ended
  assign len_o = cnt_q;
  assign lvl_o = lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q   <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      lrck_q <= lrck_i;
      if (evt_o.any) begin
        synced_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frame_classifier.sv
module frame_classifier
  import serial_audio_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WORD_W   = 16,
  parameter int SYNC_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lr_evt_t          evt_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             sync_o,
  output logic             err_o,
  output logic             dsp_o
);
  localparam logic [CNT_W-1:0] SYNC_LEN = CNT_W'(SYNC_MAX);
  localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(WORD_W);

  logic dsp_q;

  assign sync_o = evt_i.fall & evt_i.synced & (len_i <= SYNC_LEN);
  // low gap between DSP frames is not length-checked
  assign err_o  = evt_i.any & evt_i.synced & ~sync_o & ~(evt_i.rise & dsp_q)
                & (len_i < WORD_LEN);
  assign dsp_o  = dsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dsp_q <= 1'b0;
    else if (evt_i.fall && evt_i.synced) dsp_q <= sync_o;
  end
endmodule

// File: rtl/sample_shifter.sv
module sample_shifter #(
  parameter int SR_W = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            din_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q;

  assign sr_o = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_W-2:0], din_i};
  end
endmodule

// File: rtl/frame_assembler.sv
module frame_assembler
  import serial_audio_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8,
  localparam int SR_W  = 2*WORD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              din_i,
  input  lr_evt_t           evt_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              lvl_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic              sync_i,
  input  logic              err_i,
  input  logic              dsp_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int DCNT_W = $clog2(2*WORD_W + 1);
  localparam logic [DCNT_W-1:0] DCNT_MAX = '1;
  localparam logic [DCNT_W-1:0] DONE_A   = DCNT_W'(2*WORD_W);
  localparam logic [DCNT_W-1:0] DONE_B   = DCNT_W'(2*WORD_W - 1);
  localparam logic [CNT_W-1:0]  WORD_LEN = CNT_W'(WORD_W);

  cap_mode_e           mode;
  logic [WORD_W-1:0]   rj_word;
  logic [WORD_W-1:0]   i2s_word;
  logic [2*WORD_W-1:0] dsp_word;
  logic [DCNT_W-1:0]   done_at;
  logic [DCNT_W-1:0]   dcnt_q;
  logic                arm_q;
  logic                left_ok_q;
  logic [WORD_W-1:0]   left_hold_q;

  always_comb begin
    if (dsp_i || sync_i) mode = CAP_DSP;
    else if (fmt_i)      mode = CAP_RJ;
    else                 mode = CAP_I2S;
  end

  assign rj_word  = sr_i[WORD_W-1:0];
  assign i2s_word = {sr_i[WORD_W-2:0], din_i};
  assign dsp_word = {sr_i, din_i};
  assign done_at  = fmt_i ? DONE_B : DONE_A;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
      dcnt_q      <= DCNT_MAX;
      arm_q       <= 1'b0;
      left_ok_q   <= 1'b0;
      left_hold_q <= '0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= err_i;

      // DSP: count edges from each rise; keep the frame only if the pulse proved short
      if (evt_i.rise)                 dcnt_q <= DCNT_W'(1);
      else if (dcnt_q != DCNT_MAX)    dcnt_q <= dcnt_q + DCNT_W'(1);

      if (evt_i.rise)                 arm_q <= 1'b0;
      else if (sync_i && evt_i.fall)  arm_q <= 1'b1;

      if (arm_q && dcnt_q == done_at) begin
        left_o  <= dsp_word[2*WORD_W-1:WORD_W];
        right_o <= dsp_word[WORD_W-1:0];
        valid_o <= 1'b1;
        arm_q   <= 1'b0;
      end

      if (err_i) begin
        left_ok_q <= 1'b0;
      end else if (mode == CAP_RJ && evt_i.any && evt_i.synced) begin
        if (lvl_i) begin
          left_hold_q <= rj_word;
          left_ok_q   <= 1'b1;
        end else if (left_ok_q) begin
          left_o    <= left_hold_q;
          right_o   <= rj_word;
          valid_o   <= 1'b1;
          left_ok_q <= 1'b0;
        end
      end else if (mode == CAP_I2S && evt_i.synced && len_i == WORD_LEN) begin
        if (!lvl_i) begin
          left_hold_q <= i2s_word;
          left_ok_q   <= 1'b1;
        end else if (left_ok_q) begin
          left_o    <= left_hold_q;
          right_o   <= i2s_word;
          valid_o   <= 1'b1;
          left_ok_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 8,
  parameter int SYNC_MAX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lrck_i,
  input  logic              sdata_i,
  input  logic              fmt_sel_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int SR_W = 2*WORD_W - 1;

  lr_evt_t          ev;
  logic [CNT_W-1:0] lvl_len;
  logic             lvl_cur;
  logic [SR_W-1:0]  sr;
  logic             is_sync;
  logic             len_err;
  logic             dsp_mode;

  lrck_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrck_i (lrck_i),
    .evt_o  (ev),
    .len_o  (lvl_len),
    .lvl_o  (lvl_cur)
  );

  frame_classifier #(.CNT_W(CNT_W), .WORD_W(WORD_W), .SYNC_MAX(SYNC_MAX)) u_class (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (ev),
    .len_i  (lvl_len),
    .sync_o (is_sync),
    .err_o  (len_err),
    .dsp_o  (dsp_mode)
  );

  sample_shifter #(.SR_W(SR_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (sdata_i),
    .sr_o   (sr)
  );

  frame_assembler #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt_sel_i),
    .din_i   (sdata_i),
    .evt_i   (ev),
    .len_i   (lvl_len),
    .lvl_i   (lvl_cur),
    .sr_i    (sr),
    .sync_i  (is_sync),
    .err_i   (len_err),
    .dsp_i   (dsp_mode),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o),
    .err_o   (frame_err_o)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 8,
  parameter int SYNC_MAX = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lrck_i,
  input logic             fmt_sel_i,
  input logic             valid_o,
  input logic             frame_err_o,
  input logic             ev_any,
  input logic             ev_fall,
  input logic             ev_synced,
  input logic [CNT_W-1:0] lvl_len,
  input logic             dsp_mode
);
  localparam logic [CNT_W-1:0] SYNC_LEN = CNT_W'(SYNC_MAX);
  localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(WORD_W);

  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_err_blocks_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !valid_o);

  assert_short_level_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_any && ev_synced && !dsp_mode && lvl_len < WORD_LEN
     && !(ev_fall && lvl_len <= SYNC_LEN)) |=> frame_err_o);

  assert_sync_no_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_fall && ev_synced && lvl_len <= SYNC_LEN) |=> !frame_err_o);

  assert_rj_left_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_sel_i && !dsp_mode && valid_o) |-> ($past(lrck_i) && !$past(lrck_i, 2)));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(
  .WORD_W(WORD_W), .CNT_W(CNT_W), .SYNC_MAX(SYNC_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lrck_i      (lrck_i),
  .fmt_sel_i   (fmt_sel_i),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o),
  .ev_any      (ev.any),
  .ev_fall     (ev.fall),
  .ev_synced   (ev.synced),
  .lvl_len     (lvl_len),
  .dsp_mode    (dsp_mode)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
  localparam int CLK_P = 10;
  localparam int SMAX  = 1024;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic        fmt_sel = 1'b0;
  logic [15:0] left, right;
  logic        valid, ferr;

  serial_audio_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_sel_i(fmt_sel), .left_o(left), .right_o(right),
    .valid_o(valid), .frame_err_o(ferr)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit playing = 0;
  bit prev_valid = 0;
  int err_seen = 0;
  string cur_req = "R2";

  bit lr [SMAX];
  bit sd [SMAX];
  int wp;
  int seq = 0;
  logic [15:0] exp_l [64];
  logic [15:0] exp_r [64];
  int exp_wr, exp_rd;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] pat(int n);
    return 16'(n * 40503 + 4660);
  endfunction

  task automatic clear_stream();
    for (int t = 0; t < SMAX; t++) begin
      lr[t] = 1'b0;
      sd[t] = 1'(((t * 37 + 11) % 7) < 3);
    end
    wp = 0; exp_wr = 0; exp_rd = 0;
  endtask

  task automatic put_word(int pos, logic [15:0] w);
    for (int i = 0; i < 16; i++) sd[pos + i] = w[15 - i];
  endtask

  task automatic fill(int len, bit v);
    for (int i = 0; i < len; i++) lr[wp + i] = v;
    wp += len;
  endtask

  task automatic expect_pair(logic [15:0] l, logic [15:0] r);
    exp_l[exp_wr] = l; exp_r[exp_wr] = r; exp_wr++;
  endtask

  task automatic i2s_frame(int ll, int rl);
    logic [15:0] wl, wr;
    wl = pat(seq); wr = pat(seq + 1); seq += 2;
    put_word(wp + 1, wl); fill(ll, 1'b0);
    put_word(wp + 1, wr); fill(rl, 1'b1);
    expect_pair(wl, wr);
  endtask

  task automatic rj_frame(int ll, int rl);
    logic [15:0] wl, wr;
    wl = pat(seq); wr = pat(seq + 1); seq += 2;
    put_word(wp + ll - 16, wl); fill(ll, 1'b1);
    put_word(wp + rl - 16, wr); fill(rl, 1'b0);
    expect_pair(wl, wr);
  endtask

  task automatic dsp_frame(int p, int n, int off);
    logic [15:0] wl, wr;
    wl = pat(seq); wr = pat(seq + 1); seq += 2;
    put_word(wp + off, wl);
    put_word(wp + off + 16, wr);
    fill(p, 1'b1); fill(n - p, 1'b0);
    expect_pair(wl, wr);
  endtask

  always @(negedge clk) begin
    if (rst_ni && playing) begin
      if (ferr) err_seen++;
      if (valid) begin
        if (prev_valid) check(1'b0, "R7", "valid longer than one cycle", 1, 0);
        if (exp_rd < exp_wr) begin
          check(left == exp_l[exp_rd], cur_req, "left sample", int'(left), int'(exp_l[exp_rd]));
          check(right == exp_r[exp_rd], cur_req, "right sample", int'(right), int'(exp_r[exp_rd]));
          exp_rd++;
        end else begin
          check(1'b0, cur_req, "unexpected valid", 1, 0);
        end
      end
      prev_valid = valid;
    end
  end

  task automatic run_stream(bit fmt, string req, int exp_err);
    cur_req = req;
    playing = 0; prev_valid = 0; err_seen = 0;
    rst_ni = 1'b0; lrck = 1'b0; sdata = 1'b0; fmt_sel = fmt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(left == 16'h0 && right == 16'h0 && !valid && !ferr, "R1", "outputs in reset",
          int'({valid, ferr, left, right}), 0);
    rst_ni = 1'b1;
    playing = 1;
    for (int t = 0; t < wp; t++) begin
      lrck = lr[t]; sdata = sd[t];
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    playing = 0;
    check(exp_rd == exp_wr, "R7", "frames presented", exp_rd, exp_wr);
    check(err_seen == exp_err, (exp_err == 0) ? req : "R8", "framing error pulses",
          err_seen, exp_err);
  endtask

  initial begin
    // I2S, level lengths from the minimum upward
    for (int len = 16; len <= 22; len++) begin
      clear_stream();
      fill(20, 1'b1);
      for (int f = 0; f < 3; f++) i2s_frame(len, len + f);
      fill(20, 1'b0);
      run_stream(1'b0, "R2", 0);
    end

    // right-justified, uneven duty
    for (int len = 16; len <= 22; len++) begin
      clear_stream();
      fill(20, 1'b0);
      for (int f = 0; f < 3; f++) rj_frame(len, len + 3 - f);
      fill(20, 1'b1);
      run_stream(1'b1, "R3", 0);
    end

    // DSP: sync width 1..4, both MSB positions (R4 no error)
    for (int m = 0; m < 2; m++) begin
      for (int p = 1; p <= 4; p++) begin
        clear_stream();
        fill(40, 1'b0);
        for (int f = 0; f < 3; f++) dsp_frame(p, 40 + f, (m == 0) ? 1 : 0);
        fill(10, 1'b0);
        run_stream(1'(m), (m == 0) ? "R5" : "R6", 0);
      end
    end

    // R8 I2S: short left level, then a 5-edge high pulse
    clear_stream();
    fill(20, 1'b1);
    i2s_frame(20, 20);
    fill(10, 1'b0);
    fill(20, 1'b1);
    i2s_frame(20, 20);
    fill(20, 1'b0);
    fill(5, 1'b1);
    i2s_frame(20, 20);
    fill(20, 1'b0);
    run_stream(1'b0, "R8", 2);

    // R8 right-justified: short right level, then short left level
    clear_stream();
    fill(20, 1'b0);
    rj_frame(20, 20);
    fill(20, 1'b1);
    fill(12, 1'b0);
    rj_frame(20, 20);
    fill(9, 1'b1);
    fill(20, 1'b0);
    rj_frame(20, 20);
    fill(20, 1'b1);
    run_stream(1'b1, "R8", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule